// File: doc/BRIEF.md
# Sparse Matrix-Vector Multiply Engine

The engine computes z = M * x for a square matrix M kept in compressed-sparse-row form. The matrix is held as three on-chip arrays. One holds the nonzero values, one holds the column number of each of those values, and one holds, for every row, the position where that row's entries begin. A fourth on-chip array holds the dense input vector x. All four arrays are filled through one shared write port, and a select field picks the target array.

After a start pulse the engine visits the rows in order. For each entry of a row it first reads the column number, then uses that number to fetch the vector element, multiplies it by the stored value, and adds the product into a per-row accumulator. The multiply-accumulate path takes one entry per clock. When a row's last product has left the pipeline, the saturated row sum appears on the output together with its row number and a valid strobe. A one-cycle done pulse follows the final row. All arithmetic is signed fixed-point.

Top module: `spmv_engine`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, `z_valid` and `done` are low.
- R2: Row r covers the entry positions p with rowstart[r] <= p < rowstart[r+1]. The row-start array holds nrow+1 values, at addresses 0..nrow.
- R3: Each entry p adds the signed product value[p] * x[column[p]] to its row's sum. Value and x elements are two's-complement `VAL_W`-bit numbers.
- R4: The sum starts from zero for every row. A row with rowstart[r] == rowstart[r+1] yields exactly 0.
- R5: Exactly one result is produced per row, in ascending row order 0..nrow-1, with `z_row` equal to the row number. Two results never appear in adjacent cycles.
- R6: The row sum is kept without overflow for up to `MAX_ENT` entries. It is saturated to the signed `OUT_W`-bit range before output.
- R7: `done` is high for exactly one cycle, in the cycle right after the last row's `z_valid`.
- R8: Entries stream at one per clock. With start sampled at clock edge 1, `done` is high after edge 9 + nnz + 2*(nrow-1), where nnz is the number of entries covered.
- R9: A start while a run is in progress has no effect on that run's results or timing. A start with `nrow` equal to 0 or above `MAX_ROWS` is ignored and gives no result and no `done`.
- R10: The write select codes are: 0 for the value array, 1 for the column array (low log2(MAX_ROWS) bits of the data), 2 for the row-start array (low bits of the data), and 3 for the vector. Each write goes to the addressed element of the selected array only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Array write strobe |
| wr_sel | input | 2 | Target array select (R10 codes) |
| wr_addr | input | log2(MAX_ENT) | Element address within the selected array |
| wr_data | input | VAL_W | Write data |
| nrow | input | log2(MAX_ROWS+1) | Number of rows and columns for the next run |
| start | input | 1 | Start pulse |
| z_valid | output | 1 | Row result strobe |
| z_row | output | log2(MAX_ROWS+1) | Row number of the current result |
| z_data | output | OUT_W | Saturated row sum |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong row boundary or a stale entry pointer moves products between neighbouring rows. That shows up as two wrong `z_data` values at the next `z_valid` strobes, or as an extra or missing strobe. A skew between the value path and the vector path mixes up operand pairs, so every row with two or more entries reads back a wrong sum. An accumulator that is not cleared carries its error into every later row. An extra stall in the sequencer moves `done` away from the cycle count of R8, which the bench checks on every run.

// File: rtl/spmv_pkg.sv
// Shared types for the sparse matrix-vector engine.
// Assumes: nothing beyond standard packed types.
package spmv_pkg;

    // Array select codes on the shared write port
    localparam logic [1:0] SEL_VAL = 2'd0;
    localparam logic [1:0] SEL_COL = 2'd1;
    localparam logic [1:0] SEL_ROW = 2'd2;
    localparam logic [1:0] SEL_VEC = 2'd3;

    // Sequencer states
    typedef enum logic [2:0] {
        W_IDLE,
        W_ADDR0,
        W_LO,
        W_HI,
        W_RUN,
        W_WAIT
    } wstate_t;

    // Token travelling down the multiply-accumulate pipeline
    typedef struct packed {
        logic ent;   // an entry to multiply and add
        logic eor;   // end of row: emit and clear the sum
        logic last;  // this end of row closes the final row
    } tok_t;

endpackage

// File: rtl/spmv_ram.sv
// Simple one-write, one-read memory with a registered read port.
// Assumes: writes beyond DEPTH are dropped; reads beyond DEPTH return zero.
module spmv_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

    logic [W-1:0] mem [DEPTH];

    // Store a word when the write address lies inside the array
    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < DEPTH_C)) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read, one cycle of latency
    always_ff @(posedge clk) begin
        if ({1'b0, raddr} < DEPTH_C) begin
            rdata <= mem[raddr];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/spmv_walker.sv
// Row and entry sequencer. It reads the row-start array to find each row's
// bounds, then issues one entry address per cycle, followed by one end-of-row
// token per row. It waits for the done pulse before it accepts a new start.
// Assumes: the row-start array is non-decreasing; memories have one cycle of read latency.
module spmv_walker
    import spmv_pkg::*;
#(
    parameter int MAX_ROWS = 16,
    parameter int MAX_ENT  = 64,
    parameter int RAW      = 5,
    parameter int EW       = 7,
    parameter int EAW      = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [RAW-1:0] nrow,
    output logic [RAW-1:0] rs_addr,
    input  logic [EW-1:0]  rs_q,
    output logic [EAW-1:0] ent_addr,
    output tok_t           tok_out,
    output logic           clr,
    input  logic           done_in
);
    localparam logic [RAW-1:0] ROWS_C = RAW'(MAX_ROWS);

    wstate_t        state;
    logic [RAW-1:0] r;
    logic [RAW-1:0] lim;
    logic [EW-1:0]  lo;
    logic [EW-1:0]  hi;
    logic [EW-1:0]  ci;
    logic           go;
    logic           in_row;
    logic           at_last;

    assign go       = (state == W_IDLE) && start && (nrow != '0) && (nrow <= ROWS_C);
    assign clr      = go;
    assign in_row   = (ci < hi);
    assign at_last  = (r == lim);
    assign ent_addr = ci[EAW-1:0];

    // Row-start read address and pipeline token for this cycle
    always_comb begin
        tok_out = '0;
        rs_addr = r;
        case (state)
            W_LO:  rs_addr = r + RAW'(1);
            W_RUN: begin
                if (in_row) begin
                    tok_out.ent = 1'b1;
                end else begin
                    tok_out.eor  = 1'b1;
                    tok_out.last = at_last;
                    if (!at_last) rs_addr = r + RAW'(2);
                end
            end
            default: rs_addr = r;
        endcase
    end

    // Sequencer state, row counter and entry bounds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
            r     <= '0;
            lim   <= '0;
            lo    <= '0;
            hi    <= '0;
            ci    <= '0;
        end else begin
            case (state)
                W_IDLE: if (go) begin
                    r     <= '0;
                    lim   <= nrow - RAW'(1);
                    state <= W_ADDR0;
                end
                W_ADDR0: state <= W_LO;
                W_LO: begin
                    lo    <= rs_q;
                    state <= W_HI;
                end
                W_HI: begin
                    hi    <= rs_q;
                    ci    <= lo;
                    state <= W_RUN;
                end
                W_RUN: begin
                    if (in_row) begin
                        ci <= ci + EW'(1);
                    end else if (at_last) begin
                        state <= W_WAIT;
                    end else begin
                        r     <= r + RAW'(1);
                        lo    <= hi;
                        state <= W_HI;
                    end
                end
                W_WAIT: if (done_in) state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spmv_mac.sv
// Multiply-accumulate pipeline. Stage 1 holds the column and value read data,
// stage 2 the vector element, stage 3 the product. Accumulation and output
// follow. The end-of-row token travels behind the row's last entry, so the
// result is emitted only after every product of the row has been added.
// Assumes: the vector memory is read with one cycle of latency from x_addr.
module spmv_mac
    import spmv_pkg::*;
#(
    parameter int VAL_W = 16,
    parameter int OUT_W = 24,
    parameter int ACC_W = 39,
    parameter int CW    = 4,
    parameter int RAW   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  tok_t                    tok_in,
    input  logic signed [VAL_W-1:0] val_q,
    input  logic [CW-1:0]           cidx_q,
    output logic [CW-1:0]           x_addr,
    input  logic signed [VAL_W-1:0] x_q,
    output logic                    z_valid,
    output logic [RAW-1:0]          z_row,
    output logic [OUT_W-1:0]        z_data,
    output logic                    done
);
    localparam int PW = 2 * VAL_W;
    localparam logic signed [ACC_W-1:0] SAT_HI =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO =
        {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    tok_t                    tok1, tok2, tok3;
    logic signed [VAL_W-1:0] val_d;
    logic signed [PW-1:0]    prod_q;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] prod_ext;
    logic [OUT_W-1:0]        sat_val;
    logic [RAW-1:0]          row_cnt;
    logic                    fin_q;

    assign x_addr   = cidx_q;
    assign prod_ext = {{(ACC_W-PW){prod_q[PW-1]}}, prod_q};

    // Clamp the running sum into the output range
    always_comb begin
        if (acc > SAT_HI)      sat_val = SAT_HI[OUT_W-1:0];
        else if (acc < SAT_LO) sat_val = SAT_LO[OUT_W-1:0];
        else                   sat_val = acc[OUT_W-1:0];
    end

    // Token pipeline, operand alignment and product register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok1   <= '0;
            tok2   <= '0;
            tok3   <= '0;
            val_d  <= '0;
            prod_q <= '0;
        end else begin
            tok1   <= tok_in;
            tok2   <= tok1;
            tok3   <= tok2;
            val_d  <= val_q;
            prod_q <= val_d * x_q;
        end
    end

    // Row accumulator, cleared at each row end and at run start
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (tok3.eor) begin
            acc <= '0;
        end else if (tok3.ent) begin
            acc <= acc + prod_ext;
        end
    end

    // Result strobe, row numbering and the end-of-run pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_valid <= 1'b0;
            z_row   <= '0;
            z_data  <= '0;
            row_cnt <= '0;
            fin_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            z_valid <= tok3.eor;
            fin_q   <= tok3.eor && tok3.last;
            done    <= fin_q;
            if (clr) begin
                row_cnt <= '0;
            end else if (tok3.eor) begin
                z_row   <= row_cnt;
                z_data  <= sat_val;
                row_cnt <= row_cnt + RAW'(1);
            end
        end
    end

endmodule

// File: rtl/spmv_engine.sv
// Top of the sparse matrix-vector engine: four arrays, the row sequencer and
// the multiply-accumulate pipeline.
// Assumes: MAX_ENT > MAX_ROWS, and log2(MAX_ENT+1) <= VAL_W.
module spmv_engine
    import spmv_pkg::*;
#(
    parameter int VAL_W    = 16,
    parameter int OUT_W    = 24,
    parameter int MAX_ROWS = 16,
    parameter int MAX_ENT  = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_sel,
    input  logic [$clog2(MAX_ENT)-1:0]        wr_addr,
    input  logic [VAL_W-1:0]                  wr_data,
    input  logic [$clog2(MAX_ROWS+1)-1:0]     nrow,
    input  logic                              start,
    output logic                              z_valid,
    output logic [$clog2(MAX_ROWS+1)-1:0]     z_row,
    output logic [OUT_W-1:0]                  z_data,
    output logic                              done
);
    localparam int EAW   = $clog2(MAX_ENT);
    localparam int EW    = $clog2(MAX_ENT + 1);
    localparam int RAW   = $clog2(MAX_ROWS + 1);
    localparam int CW    = $clog2(MAX_ROWS);
    localparam int ACC_W = 2 * VAL_W + $clog2(MAX_ENT) + 1;

    logic [RAW-1:0]   rs_addr;
    logic [EW-1:0]    rs_q;
    logic [EAW-1:0]   ent_addr;
    logic [VAL_W-1:0] val_q;
    logic [CW-1:0]    cidx_q;
    logic [CW-1:0]    x_addr;
    logic [VAL_W-1:0] x_q;
    tok_t             tok;
    logic             clr;

    spmv_ram #(.W(VAL_W), .DEPTH(MAX_ENT), .AW(EAW)) val_ram (
        .clk(clk), .we(wr_en && (wr_sel == SEL_VAL)), .waddr(wr_addr),
        .wdata(wr_data), .raddr(ent_addr), .rdata(val_q));

    spmv_ram #(.W(CW), .DEPTH(MAX_ENT), .AW(EAW)) col_ram (
        .clk(clk), .we(wr_en && (wr_sel == SEL_COL)), .waddr(wr_addr),
        .wdata(wr_data[CW-1:0]), .raddr(ent_addr), .rdata(cidx_q));

    spmv_ram #(.W(EW), .DEPTH(MAX_ROWS + 1), .AW(RAW)) row_ram (
        .clk(clk), .we(wr_en && (wr_sel == SEL_ROW)), .waddr(wr_addr[RAW-1:0]),
        .wdata(wr_data[EW-1:0]), .raddr(rs_addr), .rdata(rs_q));

    spmv_ram #(.W(VAL_W), .DEPTH(MAX_ROWS), .AW(CW)) vec_ram (
        .clk(clk), .we(wr_en && (wr_sel == SEL_VEC)), .waddr(wr_addr[CW-1:0]),
        .wdata(wr_data), .raddr(x_addr), .rdata(x_q));

    spmv_walker #(
        .MAX_ROWS(MAX_ROWS), .MAX_ENT(MAX_ENT), .RAW(RAW), .EW(EW), .EAW(EAW)
    ) walker_i (
        .clk(clk), .rst_n(rst_n), .start(start), .nrow(nrow),
        .rs_addr(rs_addr), .rs_q(rs_q), .ent_addr(ent_addr),
        .tok_out(tok), .clr(clr), .done_in(done));

    spmv_mac #(
        .VAL_W(VAL_W), .OUT_W(OUT_W), .ACC_W(ACC_W), .CW(CW), .RAW(RAW)
    ) mac_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tok_in(tok),
        .val_q(val_q), .cidx_q(cidx_q), .x_addr(x_addr), .x_q(x_q),
        .z_valid(z_valid), .z_row(z_row), .z_data(z_data), .done(done));

endmodule

// File: rtl/spmv_engine_chk.sv
// Protocol checker for the engine's result stream, attached by bind.
// Assumes: synchronous active-low reset.
module spmv_engine_chk #(
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          z_valid,
    input logic [RW-1:0] z_row,
    input logic          done
);
    logic [RW-1:0] exp_row;
    logic          rst_prev;

    // Row number the next result should carry
    always_ff @(posedge clk) begin
        if (!rst_n || done) exp_row <= '0;
        else if (z_valid)   exp_row <= exp_row + RW'(1);
    end

    // Remember that reset was low at the previous edge
    always_ff @(posedge clk) begin
        rst_prev <= !rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_prev) begin
            reset_quiet_chk: assert (!z_valid && !done);
        end
    end

    // R5
    row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_valid |-> (z_row == exp_row));

    // R5
    result_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_valid |=> !z_valid);

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(z_valid));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind spmv_engine spmv_engine_chk #(.RW(RAW)) chk_i (
    .clk(clk), .rst_n(rst_n), .z_valid(z_valid), .z_row(z_row), .done(done));

// File: tb/spmv_engine_tb_top.sv
module spmv_engine_tb_top;
    localparam int RMAX = 16;
    localparam int EMAX = 64;
    localparam longint SHI = 64'sd8388607;
    localparam longint SLO = -64'sd8388608;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  nrow = '0;
    logic        start = 1'b0;
    logic        z_valid;
    logic [4:0]  z_row;
    logic [23:0] z_data;
    logic        done;

    int total = 0;
    int bad = 0;
    int bv [EMAX];
    int bc [EMAX];
    int brs [RMAX+1];
    int bx [RMAX];

    always #10 clk = ~clk;

    spmv_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .nrow(nrow), .start(start),
        .z_valid(z_valid), .z_row(z_row), .z_data(z_data), .done(done));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint row_sum(input int r);
        longint s = 0;
        for (int p = brs[r]; p < brs[r+1]; p++) s += longint'(bv[p]) * longint'(bx[bc[p]]);
        if (s > SHI) s = SHI;
        if (s < SLO) s = SLO;
        return s;
    endfunction

    task automatic wr(input logic [1:0] sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = addr[5:0]; wr_data = data[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R10: load all four arrays with select codes 0..3
    task automatic load(input int nr);
        for (int i = 0; i <= nr; i++) wr(2'd2, i, brs[i]);
        for (int p = brs[0]; p < brs[nr]; p++) begin
            wr(2'd0, p, bv[p]);
            wr(2'd1, p, bc[p]);
        end
        for (int i = 0; i < nr; i++) wr(2'd3, i, bx[i]);
    endtask

    // R2 R3 R4 R5 R6 R8 R9: run and compare every row, then count cycles
    task automatic run(input int nr, input bit poke);
        int cyc = 0;
        int got = 0;
        int exp_cyc;
        exp_cyc = 9 + (brs[nr] - brs[0]) + 2 * (nr - 1);
        @(negedge clk);
        nrow = nr[4:0];
        start = 1'b1;
        while (!done && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = poke && (cyc == 6 || cyc == exp_cyc - 3);
            if (z_valid) begin
                check(z_row == got[4:0], "R5 row order", z_row, got);
                check($signed(z_data) == row_sum(got), "R2/R3/R6 row sum", $signed(z_data), row_sum(got));
                got++;
            end
        end
        start = 1'b0;
        check(got == nr, "R5 result count", got, nr);
        check(cyc == exp_cyc, "R8 cycles to done", cyc, exp_cyc);
        @(negedge clk);
        check(!done, "R7 done single pulse", done, 0);
    endtask

    task automatic rand_case(input int nr, input bit big);
        int p = 0;
        for (int r = 0; r < nr; r++) begin
            int len = $urandom % 5;
            brs[r] = p;
            for (int k = 0; k < len; k++) begin
                bc[p] = $urandom % nr;
                bv[p] = big ? (int'($urandom % 65536) - 32768) : (int'($urandom % 201) - 100);
                p++;
            end
        end
        brs[nr] = p;
        for (int i = 0; i < nr; i++)
            bx[i] = big ? (int'($urandom % 65536) - 32768) : (int'($urandom % 201) - 100);
    endtask

    initial begin
        int idle_hits;
        int refc [13] = '{0, 1, 3, 1, 3, 0, 2, 3, 5, 2, 2, 4, 5};
        int refr [7]  = '{0, 3, 5, 9, 10, 12, 13};
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: quiet during reset
        check(!z_valid && !done, "R1 reset outputs", {z_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!z_valid && !done, "R1 after release", {z_valid, done}, 0);

        // Directed: reference layout, six rows, thirteen entries
        for (int p = 0; p < 13; p++) begin bc[p] = refc[p]; bv[p] = p * 7 - 30; end
        for (int i = 0; i < 7; i++) brs[i] = refr[i];
        for (int i = 0; i < 6; i++) bx[i] = i * 3 - 5;
        load(6);
        run(6, 1'b0);
        // R9: extra start pulses mid-run change nothing
        run(6, 1'b1);

        // R4: empty first and last rows
        brs[0] = 0; brs[1] = 0; brs[2] = 2; brs[3] = 2;
        bc[0] = 1; bv[0] = 9; bc[1] = 2; bv[1] = -4;
        bx[0] = 100; bx[1] = 11; bx[2] = 13;
        load(3);
        run(3, 1'b0);

        // R6: positive and negative saturation with full-length rows
        brs[0] = 0; brs[1] = 40; brs[2] = 64;
        for (int p = 0; p < 64; p++) begin
            bc[p] = (p < 40) ? 0 : 1;
            bv[p] = (p < 40) ? 32767 : -32768;
        end
        bx[0] = 32767; bx[1] = 32767;
        load(2);
        run(2, 1'b0);

        // R9: nrow of zero is ignored
        idle_hits = 0;
        @(negedge clk);
        nrow = 5'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (z_valid || done) idle_hits++;
        end
        check(idle_hits == 0, "R9 nrow zero ignored", idle_hits, 0);

        // Random layouts, small and full-range values
        for (int t = 0; t < 8; t++) begin
            int nr = 1 + int'($urandom % 16);
            rand_case(nr, t[0]);
            load(nr);
            run(nr, t == 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule